// File: doc/BRIEF.md
# Bus-Matching Dual-Clock FIFO

This block is a first-in first-out buffer that links two unrelated clock domains. The write side takes one 36-bit long word per accepted cycle on its own clock. The read side runs on a second clock, and its output width can be set to 36, 18 or 9 bits. When the read side is narrower than a long word, each stored entry is delivered as two halves or four bytes, least significant part first. The storage location is returned to the writer only when the final part of the entry has been read.

Each port accepts a transfer only when four controls agree: an active-low select, a direction bit, an active-low mailbox-path select that must be low, and an enable. The write side raises a full flag. The read side raises an almost-empty flag once its fill level drops to a parameter threshold or below. Each side computes its flag from its own pointer and a Gray-coded copy of the other side's pointer, taken through a flop synchronizer. Read data passes through an output register, which keeps its value until the next accepted read.

Top module: `bm_async_fifo`

## Requirements
- R1: A write is stored on a rising `clk_a` edge only when `wr_sel_n`=0, `wr_dir`=0, `wr_mbx`=0 and `wr_en`=1. Any other combination stores nothing.
- R2: A read is taken on a rising `clk_b` edge only when `rd_sel_n`=0, `rd_dir`=1, `rd_mbx`=0 and `rd_en`=1. Any other combination leaves `rd_data` unchanged.
- R3: `rd_data` changes only on an accepted read and otherwise holds the last part read. It resets to 0.
- R4: With `rd_width`=00 (36-bit), long words are read out whole, in the order they were written.
- R5: With `rd_width`=01 (18-bit), each long word is read as bits 17:0 first and then bits 35:18. Each half appears on `rd_data[17:0]`, and bits 35:18 are zero.
- R6: With `rd_width`=10 (9-bit), each long word is read as bits 8:0, 17:9, 26:18 and then 35:27. Each byte appears on `rd_data[8:0]`, and bits 35:9 are zero.
- R7: `full` goes high once DEPTH long words are stored. A write attempted while `full` is high is discarded and does not disturb the stored data. `full` is 0 after reset.
- R8: When a read frees a location, `full` falls within a few `clk_a` cycles. In a narrow read mode, `full` stays high until the last part of the long word has been read.
- R9: `almost_empty` is 1 after reset and whenever the fill level is AE_OFF or less. It falls a few `clk_b` cycles after a write raises the level to AE_OFF+1.
- R10: In a narrow read mode, reading the earlier parts of a long word does not change `almost_empty`. Reading its last part is what brings the level down.
- R11: A read attempted while the FIFO is empty is discarded and leaves `rd_data` and the part sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| rst_a_n | input | 1 | Write-side asynchronous reset, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| wr_dir | input | 1 | Write port direction; 0 means write |
| wr_mbx | input | 1 | Write-side mailbox-path select; must be 0 for a FIFO write |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Long word to store |
| full | output | 1 | FIFO full (write domain) |
| clk_b | input | 1 | Read-side clock |
| rst_b_n | input | 1 | Read-side asynchronous reset, active low |
| rd_sel_n | input | 1 | Read port select, active low |
| rd_dir | input | 1 | Read port direction; 1 means read |
| rd_mbx | input | 1 | Read-side mailbox-path select; must be 0 for a FIFO read |
| rd_en | input | 1 | Read enable |
| rd_width | input | 2 | Read width: 00 = 36-bit, 01 = 18-bit, 10 = 9-bit |
| rd_data | output | 36 | Registered read data |
| almost_empty | output | 1 | Level at or below AE_OFF (read domain) |

## Verification
The main data path is tested in each of the three read widths. Each long word carries a distinct value in every half and every byte, so a swapped part order or a wrong lane shows up as a data mismatch. Each qualifier is forced to its blocking value, one at a time, against a valid transfer. A missing term in the write or read qualification then shows up as an extra word or as a changed output register. The two flags are driven around their thresholds in both a whole-word mode and a narrow mode. This separates a pointer that advances on every part from one that advances only on the last part. A fill to capacity followed by an extra write and a complete drain tells a discarded write apart from one that overwrote data.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
   localparam int BMF_LW = 36;
   localparam int BMF_HW = 18;
   localparam int BMF_BW = 9;

   typedef enum logic [1:0] {
      BMF_W36 = 2'b00,
      BMF_W18 = 2'b01,
      BMF_W9  = 2'b10
   } bmf_width_e;
endpackage

// File: rtl/bmf_sync.sv
module bmf_sync #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bmf_wr_ctrl.sv
module bmf_wr_ctrl #(
   parameter int AW = 11
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic [AW:0] rgray_s,
   output logic        go,
   output logic [AW-1:0] addr,
   output logic [AW:0] wptr,
   output logic [AW:0] wgray,
   output logic        full
);
   logic [AW:0] wptr_nx;

   assign full    = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
   assign go      = req && !full;
   assign wptr_nx = wptr + 1'b1;
   assign addr    = wptr[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
      end else if (go) begin
         wptr  <= wptr_nx;
         wgray <= wptr_nx ^ (wptr_nx >> 1);
      end
   end
endmodule

// File: rtl/bmf_rd_ctrl.sv
module bmf_rd_ctrl
   import bmf_pkg::*;
#(
   parameter int AW     = 11,
   parameter int AE_OFF = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic [1:0]  width,
   input  logic [AW:0] wgray_s,
   output logic        go,
   output logic        last_part,
   output logic [1:0]  part,
   output logic [AW-1:0] addr,
   output logic [AW:0] rptr,
   output logic [AW:0] rgray,
   output logic        almost_empty
);
   localparam logic [AW:0] AE_LIM = (AW+1)'(AE_OFF);

   logic [AW:0] wbin_s;
   logic [AW:0] rptr_nx;
   logic [AW:0] level_nx;
   logic        empty;

   always_comb begin
      wbin_s[AW] = wgray_s[AW];
      for (int i = AW-1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   always_comb begin
      case (bmf_width_e'(width))
         BMF_W18: last_part = (part == 2'd1);
         BMF_W9:  last_part = (part == 2'd3);
         default: last_part = 1'b1;
      endcase
   end

   assign empty    = (rgray == wgray_s);
   assign go       = req && !empty;
   assign rptr_nx  = (go && last_part) ? rptr + 1'b1 : rptr;
   assign level_nx = wbin_s - rptr_nx;
   assign addr     = rptr[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr         <= '0;
         rgray        <= '0;
         part         <= '0;
         almost_empty <= 1'b1;
      end else begin
         rptr         <= rptr_nx;
         rgray        <= rptr_nx ^ (rptr_nx >> 1);
         almost_empty <= (level_nx <= AE_LIM);
         if (go) part <= last_part ? 2'd0 : part + 2'd1;
      end
   end
endmodule

// File: rtl/bm_async_fifo.sv
module bm_async_fifo
   import bmf_pkg::*;
#(
   parameter int DEPTH       = 2048,
   parameter int AE_OFF      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk_a,
   input  logic        rst_a_n,
   input  logic        wr_sel_n,
   input  logic        wr_dir,
   input  logic        wr_mbx,
   input  logic        wr_en,
   input  logic [35:0] wr_data,
   output logic        full,
   input  logic        clk_b,
   input  logic        rst_b_n,
   input  logic        rd_sel_n,
   input  logic        rd_dir,
   input  logic        rd_mbx,
   input  logic        rd_en,
   input  logic [1:0]  rd_width,
   output logic [35:0] rd_data,
   output logic        almost_empty
);
   localparam int AW = $clog2(DEPTH);

   if (!(DEPTH == 2048 || DEPTH == 4096 || DEPTH == 8192)) begin : g_bad_depth
      $error("bm_async_fifo: DEPTH must be 2048, 4096 or 8192");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bm_async_fifo: SYNC_STAGES must be at least 2");
   end
   if (AE_OFF < 1 || AE_OFF >= DEPTH) begin : g_bad_ae
      $error("bm_async_fifo: AE_OFF out of range");
   end

   logic          wr_qual, rd_qual;
   logic          wr_go, rd_go, last_part;
   logic [1:0]    part;
   logic [AW-1:0] waddr, raddr;
   logic [AW:0]   wptr, wgray, wgray_s;
   logic [AW:0]   rptr, rgray, rgray_s;
   logic [BMF_LW-1:0] mem [DEPTH];
   logic [BMF_LW-1:0] word;
   logic [BMF_BW-1:0] byte_l [4];
   logic [BMF_HW-1:0] half_l [2];
   logic [BMF_LW-1:0] lane;

   assign wr_qual = !wr_sel_n && !wr_dir && !wr_mbx && wr_en;
   assign rd_qual = !rd_sel_n &&  rd_dir && !rd_mbx && rd_en;

   bmf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(clk_a), .rst_n(rst_a_n), .d(rgray), .q(rgray_s));

   bmf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(clk_b), .rst_n(rst_b_n), .d(wgray), .q(wgray_s));

   bmf_wr_ctrl #(.AW(AW)) u_wr (
      .clk(clk_a), .rst_n(rst_a_n), .req(wr_qual), .rgray_s(rgray_s),
      .go(wr_go), .addr(waddr), .wptr(wptr), .wgray(wgray), .full(full));

   bmf_rd_ctrl #(.AW(AW), .AE_OFF(AE_OFF)) u_rd (
      .clk(clk_b), .rst_n(rst_b_n), .req(rd_qual), .width(rd_width),
      .wgray_s(wgray_s), .go(rd_go), .last_part(last_part), .part(part),
      .addr(raddr), .rptr(rptr), .rgray(rgray), .almost_empty(almost_empty));

   always_ff @(posedge clk_a) begin
      if (wr_go) mem[waddr] <= wr_data;
   end

   assign word = mem[raddr];

   for (genvar k = 0; k < 4; k++) begin : g_byte
      assign byte_l[k] = word[k*BMF_BW +: BMF_BW];
   end
   for (genvar k = 0; k < 2; k++) begin : g_half
      assign half_l[k] = word[k*BMF_HW +: BMF_HW];
   end

   always_comb begin
      case (bmf_width_e'(rd_width))
         BMF_W18: lane = {{(BMF_LW-BMF_HW){1'b0}}, half_l[part[0]]};
         BMF_W9:  lane = {{(BMF_LW-BMF_BW){1'b0}}, byte_l[part]};
         default: lane = word;
      endcase
   end

   always_ff @(posedge clk_b or negedge rst_b_n) begin
      if (!rst_b_n)   rd_data <= '0;
      else if (rd_go) rd_data <= lane;
   end
endmodule

// File: rtl/bmf_chk.sv
module bmf_chk #(
   parameter int AW = 11
) (
   input logic        clk_a,
   input logic        rst_a_n,
   input logic        clk_b,
   input logic        rst_b_n,
   input logic        wr_qual,
   input logic        full,
   input logic [AW:0] wptr,
   input logic        rd_qual,
   input logic        rd_go,
   input logic        last_part,
   input logic [1:0]  part,
   input logic [1:0]  rd_width,
   input logic [AW:0] rptr,
   input logic [35:0] rd_data
);
   a_r7_no_overflow: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (full && wr_qual) |=> $stable(wptr));

   a_r11_no_underflow: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (rd_qual && !rd_go) |=> ($stable(rptr) && $stable(part) && $stable(rd_data)));

   a_r3_hold_output: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      !rd_go |=> $stable(rd_data));

   a_r10_partial_keeps_ptr: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (rd_go && !last_part) |=> $stable(rptr));

   a_r4_ptr_step: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (rd_go && last_part) |=> (rptr == $past(rptr) + 1'b1));

   a_r5_half_zero_ext: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (rd_go && rd_width == 2'b01) |=> (rd_data[35:18] == '0));

   a_r6_byte_zero_ext: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (rd_go && rd_width == 2'b10) |=> (rd_data[35:9] == '0));
endmodule

bind bm_async_fifo bmf_chk #(.AW(AW)) u_chk (
   .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
   .wr_qual(wr_qual), .full(full), .wptr(wptr),
   .rd_qual(rd_qual), .rd_go(rd_go), .last_part(last_part), .part(part),
   .rd_width(rd_width), .rptr(rptr), .rd_data(rd_data));

// File: tb/bm_async_fifo_tb.sv
module bm_async_fifo_tb_top;
   localparam int DEPTH  = 2048;
   localparam int AE_OFF = 8;

   logic clk_a = 1'b0, clk_b = 1'b0;
   logic rst_a_n = 1'b0, rst_b_n = 1'b0;
   logic wr_sel_n = 1'b1, wr_dir = 1'b0, wr_mbx = 1'b0, wr_en = 1'b0;
   logic [35:0] wr_data = '0;
   logic rd_sel_n = 1'b1, rd_dir = 1'b1, rd_mbx = 1'b0, rd_en = 1'b0;
   logic [1:0] rd_width = 2'b00;
   logic full, almost_empty;
   logic [35:0] rd_data;
   int n_chk = 0, n_err = 0;

   always #2 clk_a = ~clk_a;
   always #3 clk_b = ~clk_b;

   bm_async_fifo #(.DEPTH(DEPTH), .AE_OFF(AE_OFF)) dut_i (
      .clk_a(clk_a), .rst_a_n(rst_a_n), .wr_sel_n(wr_sel_n), .wr_dir(wr_dir),
      .wr_mbx(wr_mbx), .wr_en(wr_en), .wr_data(wr_data), .full(full),
      .clk_b(clk_b), .rst_b_n(rst_b_n), .rd_sel_n(rd_sel_n), .rd_dir(rd_dir),
      .rd_mbx(rd_mbx), .rd_en(rd_en), .rd_width(rd_width), .rd_data(rd_data),
      .almost_empty(almost_empty));

   function automatic logic [35:0] pat(int i);
      return {4'hA, i[15:0], ~i[15:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [35:0] d, input logic sn = 0, input logic dr = 0,
                     input logic mb = 0, input logic en = 1);
      @(negedge clk_a);
      wr_data = d; wr_sel_n = sn; wr_dir = dr; wr_mbx = mb; wr_en = en;
      @(negedge clk_a);
      wr_sel_n = 1'b1; wr_en = 1'b0;
   endtask

   task automatic rd(input logic sn = 0, input logic dr = 1, input logic mb = 0, input logic en = 1);
      @(negedge clk_b);
      rd_sel_n = sn; rd_dir = dr; rd_mbx = mb; rd_en = en;
      @(negedge clk_b);
      rd_sel_n = 1'b1; rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk_a);
      repeat (6) @(negedge clk_b);
   endtask

   task automatic t_reset();
      chk(full == 1'b0, "R7 reset full", 36'(full), 36'd0);
      chk(almost_empty == 1'b1, "R9 reset almost_empty", 36'(almost_empty), 36'd1);
      chk(rd_data == '0, "R3 reset rd_data", rd_data, 36'd0);
   endtask

   task automatic t_wr_qual();
      rd_width = 2'b00;
      wr(36'h0_BAD0_0001, 1, 0, 0, 1);
      wr(36'h0_BAD0_0002, 0, 1, 0, 1);
      wr(36'h0_BAD0_0003, 0, 0, 1, 1);
      wr(36'h0_BAD0_0004, 0, 0, 0, 0);
      wr(36'h1_2345_6789);
      settle();
      rd();
      chk(rd_data == 36'h1_2345_6789, "R1 only qualified write stored", rd_data, 36'h1_2345_6789);
      rd();
      chk(rd_data == 36'h1_2345_6789, "R11 read while empty ignored", rd_data, 36'h1_2345_6789);
   endtask

   task automatic t_rd_qual();
      wr(36'h5_5555_0001);
      wr(36'h5_5555_0002);
      settle();
      rd(1, 1, 0, 1);
      rd(0, 0, 0, 1);
      rd(0, 1, 1, 1);
      rd(0, 1, 0, 0);
      chk(rd_data == 36'h1_2345_6789, "R2 unqualified reads ignored", rd_data, 36'h1_2345_6789);
      rd();
      chk(rd_data == 36'h5_5555_0001, "R2 qualified read", rd_data, 36'h5_5555_0001);
      repeat (5) @(negedge clk_b);
      chk(rd_data == 36'h5_5555_0001, "R3 output held while idle", rd_data, 36'h5_5555_0001);
      rd();
      chk(rd_data == 36'h5_5555_0002, "R2 second read", rd_data, 36'h5_5555_0002);
   endtask

   task automatic t_order36();
      int bad = 0;
      for (int i = 0; i < 5; i++) wr(pat(100 + i));
      settle();
      for (int i = 0; i < 5; i++) begin
         rd();
         if (rd_data != pat(100 + i)) bad++;
      end
      chk(bad == 0, "R4 36-bit order", 36'(bad), 36'd0);
   endtask

   task automatic t_w18();
      logic [35:0] w0 = 36'h3_1234_5678, w1 = 36'hC_8765_4321;
      rd_width = 2'b01;
      wr(w0); wr(w1);
      settle();
      rd(); chk(rd_data == {18'd0, w0[17:0]},  "R5 half 0", rd_data, {18'd0, w0[17:0]});
      rd(); chk(rd_data == {18'd0, w0[35:18]}, "R5 half 1", rd_data, {18'd0, w0[35:18]});
      rd(); chk(rd_data == {18'd0, w1[17:0]},  "R5 next word half 0", rd_data, {18'd0, w1[17:0]});
      rd(); chk(rd_data == {18'd0, w1[35:18]}, "R5 next word half 1", rd_data, {18'd0, w1[35:18]});
   endtask

   task automatic t_w9();
      logic [35:0] w = 36'h9_A5C3_E1F7;
      rd_width = 2'b10;
      wr(w);
      settle();
      for (int k = 0; k < 4; k++) begin
         rd();
         chk(rd_data == {27'd0, w[k*9 +: 9]}, "R6 byte lane", rd_data, {27'd0, w[k*9 +: 9]});
      end
   endtask

   task automatic t_ae();
      int bad = 0;
      rd_width = 2'b00;
      settle();
      for (int i = 0; i < AE_OFF; i++) wr(pat(200 + i));
      settle();
      chk(almost_empty == 1'b1, "R9 at threshold", 36'(almost_empty), 36'd1);
      wr(pat(200 + AE_OFF));
      settle();
      chk(almost_empty == 1'b0, "R9 above threshold", 36'(almost_empty), 36'd0);
      rd_width = 2'b10;
      rd(); rd(); rd();
      settle();
      chk(almost_empty == 1'b0, "R10 partial byte reads keep level", 36'(almost_empty), 36'd0);
      rd();
      chk(almost_empty == 1'b1, "R10 last byte lowers level", 36'(almost_empty), 36'd1);
      rd_width = 2'b00;
      for (int i = 1; i <= AE_OFF; i++) begin
         rd();
         if (rd_data != pat(200 + i)) bad++;
      end
      chk(bad == 0, "R4 drain after byte mode", 36'(bad), 36'd0);
   endtask

   task automatic t_full();
      int bad = 0;
      logic [35:0] last_half;
      rd_width = 2'b01;
      for (int i = 0; i < DEPTH; i++) wr(pat(i));
      settle();
      chk(full == 1'b1, "R7 full at DEPTH", 36'(full), 36'd1);
      wr(36'hF_FFFF_FFFF);
      rd();
      chk(rd_data == {18'd0, pat(0)[17:0]}, "R5 first half at full", rd_data, {18'd0, pat(0)[17:0]});
      settle();
      chk(full == 1'b1, "R8 full held after partial read", 36'(full), 36'd1);
      rd();
      settle();
      chk(full == 1'b0, "R8 full released after last half", 36'(full), 36'd0);
      for (int i = 1; i < DEPTH; i++) begin
         rd(); if (rd_data != {18'd0, pat(i)[17:0]})  bad++;
         rd(); if (rd_data != {18'd0, pat(i)[35:18]}) bad++;
      end
      chk(bad == 0, "R7 contents intact after write while full", 36'(bad), 36'd0);
      last_half = {18'd0, pat(DEPTH-1)[35:18]};
      rd();
      chk(rd_data == last_half, "R7 discarded write not stored", rd_data, last_half);
   endtask

   initial begin
      repeat (4) @(negedge clk_b);
      rst_a_n = 1'b1; rst_b_n = 1'b1;
      repeat (2) @(negedge clk_b);
      t_reset();
      t_wr_qual();
      t_rd_qual();
      t_order36();
      t_w18();
      t_w9();
      t_ae();
      t_full();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_a);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule